// File: doc/BRIEF.md
# Programmable Timer Bank with Watchdog

This block is a bank of four independent 32-bit down-counters. Software writes a reload value for each counter and picks what advances it: every cycle of the system clock, a count strobe from a shared prescaler (one cycle in 16 or one in 256), or rising edges seen on an external pin. An external pin passes through a synchronizer before its edges are used. When a counter steps down to zero it sets a sticky status bit. On the next count strobe it loads its reload value again, so it raises an interrupt once per period.

The last counter has an extra watchdog mode. In that mode, reaching zero does not set status. Instead it starts a 16-cycle pulse on a chip-reset output, and the counter then stays at zero. Software keeps the pulse from happening by writing the reload value again before the count runs out, which restarts the count at once. One register bus reads and writes all the state. It accepts a write in any cycle and has no back-pressure. Reads are combinational from the address.

Top module: `tmr_bank`

## Requirements
- R1: After reset, every counter, reload value, control word, status bit and mask bit is zero. `irq_o` and `wdog_rst_o` are low.
- R2: Register map on `addr`:
  - 0..3: read timer i's current count; write timer i's reload value.
  - 4..7: control word of timer i, with bit0 enable, bits[2:1] source (0 system clock, 1 prescaled, 2 external pin, 3 none), bit3 prescale ratio (0 = 16, 1 = 256), bit4 watchdog mode. Bit4 is kept only for timer 3 and reads 0 on the others.
  - 8: status.
  - 9: interrupt mask.
  - Any other address reads 0.
- R3: A write to a reload address stores the value and loads it into the counter at that clock edge. This write has priority over a count strobe in the same cycle.
- R4: With source 0, an enabled counter steps down by one every cycle. A disabled counter, or one with source 3, keeps its value.
- R5: The prescaler is free-running from reset. Ratio 16 strobes in every cycle whose index since reset is 15 mod 16. Ratio 256 strobes in every cycle whose index is 255 mod 256.
- R6: With source 2, the counter steps once for each rising edge of its `ext_in` bit. The step lands three clock edges after the pin changes.
- R7: A step from 1 to 0 sets the timer's status bit. A strobe while the count is zero reloads the counter. A reload value of 0 keeps the counter at zero and never sets status.
- R8: Writing 1 to a status bit clears it. A set in the same cycle wins over the clear. `irq_o` is high when any status bit is set and its mask bit is 1.
- R9: In watchdog mode, timer 3 reaching zero:
  - drives `wdog_rst_o` high for exactly 16 cycles, starting the next cycle;
  - sets no status;
  - leaves the counter at zero until the next reload write.

  A zero reached while a pulse is already running does not extend it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for both read and write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` (combinational) |
| ext_in | input | 4 | External count pins, one per timer, asynchronous |
| irq_o | output | 1 | Interrupt request |
| wdog_rst_o | output | 1 | Watchdog chip-reset pulse |

## Verification
Two events can fall in the same cycle and both touch the status register:
- software clearing a status bit;
- a counter stepping to zero, which sets that bit.

The bench provokes this overlap by running timer 0 from the system clock with a short period while it writes a clear to the status register on every cycle for a stretch, so at least one clear meets a set. A cycle-by-cycle reference model judges every cycle, including the collision. A set must survive the clear, and `irq_o` must follow. Reload writes that arrive while the watchdog counter is stepping are checked the same way, since the write must win.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W        = 4;
  localparam int ADDR_CTRL_LO  = 4;
  localparam int ADDR_STS      = 8;
  localparam int ADDR_MSK      = 9;

  typedef enum logic [1:0] {
    SRC_SYS = 2'd0,
    SRC_PRE = 2'd1,
    SRC_EXT = 2'd2,
    SRC_OFF = 2'd3
  } src_e;

  // bit4 wd, bit3 ratio, bits[2:1] src, bit0 en
  typedef struct packed {
    logic wd;
    logic ratio;
    src_e src;
    logic en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int LO_LOG2 = 4,
  parameter int HI_LOG2 = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_lo,
  output logic tick_hi
);
  logic [HI_LOG2-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end

  assign tick_lo = &pre_q[LO_LOG2-1:0];
  assign tick_hi = &pre_q;
endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= pin;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise = s2_q & ~s3_q;
endmodule

// File: rtl/tmr_down_counter.sv
module tmr_down_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  input  logic             hold_at_zero,
  output logic [CNT_W-1:0] cnt,
  output logic             hit_zero
);
  logic [CNT_W-1:0] cnt_q, rl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rl_q  <= '0;
    end else if (load) begin
      cnt_q <= load_val;
      rl_q  <= load_val;
    end else if (tick) begin
      if (cnt_q == '0) begin
        if (!hold_at_zero) cnt_q <= rl_q;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign cnt      = cnt_q;
  assign hit_zero = tick && !load && (cnt_q == CNT_W'(1));
endmodule

// File: rtl/tmr_pulse_stretch.sv
module tmr_pulse_stretch #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse
);
  localparam int PW = $clog2(LEN + 1);
  logic [PW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     left_q <= '0;
    else if (left_q != '0)          left_q <= left_q - 1'b1;
    else if (fire)                  left_q <= PW'(LEN);
  end

  assign pulse = (left_q != '0);
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int NUM_TIMERS  = 4,
  parameter int CNT_W       = 32,
  parameter int PRE_LO_LOG2 = 4,
  parameter int PRE_HI_LOG2 = 8,
  parameter int WDOG_LEN    = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [CNT_W-1:0]      wr_data,
  output logic [CNT_W-1:0]      rd_data,
  input  logic [NUM_TIMERS-1:0] ext_in,
  output logic                  irq_o,
  output logic                  wdog_rst_o
);
  localparam int WD_IDX = NUM_TIMERS - 1;

  ctrl_t                             ctrl_q [NUM_TIMERS];
  logic [NUM_TIMERS-1:0][CNT_W-1:0]  cnt_v;
  logic [NUM_TIMERS-1:0]             hit_v, tick_v, rise_v, sts_set, en_v;
  logic [NUM_TIMERS-1:0]             sts_q, msk_q;
  logic                              tick_lo, tick_hi, wd_fire;

  tmr_prescale #(.LO_LOG2(PRE_LO_LOG2), .HI_LOG2(PRE_HI_LOG2)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick_lo(tick_lo), .tick_hi(tick_hi)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_TIMERS; i++) ctrl_q[i] <= '0;
      msk_q <= '0;
      sts_q <= '0;
    end else begin
      for (int i = 0; i < NUM_TIMERS; i++) begin
        if (wr_en && addr == ADDR_W'(ADDR_CTRL_LO + i)) begin
          ctrl_q[i] <= ctrl_t'(wr_data[CTRL_W-1:0]);
          if (i != WD_IDX) ctrl_q[i].wd <= 1'b0;
        end
      end
      if (wr_en && addr == ADDR_W'(ADDR_MSK)) msk_q <= wr_data[NUM_TIMERS-1:0];
      if (wr_en && addr == ADDR_W'(ADDR_STS))
        sts_q <= (sts_q & ~wr_data[NUM_TIMERS-1:0]) | sts_set;
      else
        sts_q <= sts_q | sts_set;
    end
  end

  for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_tmr
    logic src_tick;

    tmr_edge_sync u_sync (
      .clk(clk), .rst_n(rst_n), .pin(ext_in[g]), .rise(rise_v[g])
    );

    always_comb begin
      unique case (ctrl_q[g].src)
        SRC_SYS: src_tick = 1'b1;
        SRC_PRE: src_tick = ctrl_q[g].ratio ? tick_hi : tick_lo;
        SRC_EXT: src_tick = rise_v[g];
        default: src_tick = 1'b0;
      endcase
    end

    assign tick_v[g]  = ctrl_q[g].en & src_tick;
    assign en_v[g]    = ctrl_q[g].en;
    assign sts_set[g] = hit_v[g] & ~ctrl_q[g].wd;

    tmr_down_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .load(wr_en && addr == ADDR_W'(g)),
      .load_val(wr_data),
      .tick(tick_v[g]),
      .hold_at_zero(ctrl_q[g].wd),
      .cnt(cnt_v[g]),
      .hit_zero(hit_v[g])
    );
  end

  assign wd_fire = hit_v[WD_IDX] & ctrl_q[WD_IDX].wd;

  tmr_pulse_stretch #(.LEN(WDOG_LEN)) u_wd (
    .clk(clk), .rst_n(rst_n), .fire(wd_fire), .pulse(wdog_rst_o)
  );

  assign irq_o = |(sts_q & msk_q);

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_TIMERS; i++) begin
      if (addr == ADDR_W'(i))                rd_data = cnt_v[i];
      if (addr == ADDR_W'(ADDR_CTRL_LO + i)) rd_data = CNT_W'(ctrl_q[i]);
    end
    if (addr == ADDR_W'(ADDR_STS)) rd_data = CNT_W'(sts_q);
    if (addr == ADDR_W'(ADDR_MSK)) rd_data = CNT_W'(msk_q);
  end
endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk
  import tmr_pkg::*;
#(
  parameter int NUM_TIMERS = 4,
  parameter int CNT_W      = 32,
  parameter int WDOG_LEN   = 16
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            wr_en,
  input logic [ADDR_W-1:0]               addr,
  input logic [CNT_W-1:0]                wr_data,
  input logic                            wdog_rst_o,
  input logic [NUM_TIMERS-1:0]           sts,
  input logic [NUM_TIMERS-1:0]           en,
  input logic [NUM_TIMERS-1:0][CNT_W-1:0] cnt
);
  localparam int RW = $clog2(WDOG_LEN + 2);
  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          run_q <= '0;
    else if (wdog_rst_o) run_q <= run_q + 1'b1;
    else                 run_q <= '0;
  end

  for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_a
    assert_sts_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sts[g] && !(wr_en && addr == ADDR_W'(ADDR_STS) && wr_data[g]) |=> sts[g]);

    assert_reload_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && addr == ADDR_W'(g) |=> cnt[g] == $past(wr_data));

    assert_disabled_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !en[g] && !(wr_en && addr == ADDR_W'(g)) |=> $stable(cnt[g]));
  end

  assert_pulse_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdog_rst_o) |-> run_q == RW'(WDOG_LEN));

  assert_pulse_max_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst_o |-> run_q < RW'(WDOG_LEN));

  assert_pulse_from_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdog_rst_o) |-> cnt[NUM_TIMERS-1] == '0);
endmodule

bind tmr_bank tmr_bank_chk #(
  .NUM_TIMERS(NUM_TIMERS), .CNT_W(CNT_W), .WDOG_LEN(WDOG_LEN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .wdog_rst_o(wdog_rst_o), .sts(sts_q), .en(en_v), .cnt(cnt_v)
);

// File: tb/tb_tmr_bank.sv
module tb_tmr_bank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [3:0]  ext_in = '0;
  logic        irq_o, wdog_rst_o;

  int n_chk = 0;
  int n_fail = 0;
  bit started = 1'b0;
  int rot = 0;

  tmr_bank dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .ext_in(ext_in), .irq_o(irq_o), .wdog_rst_o(wdog_rst_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model
  logic [31:0] m_cnt [4];
  logic [31:0] m_rl  [4];
  logic [4:0]  m_ctrl [4];
  logic [3:0]  m_sts, m_msk, m_s1, m_s2, m_s3;
  int          m_pre, m_pulse;

  function automatic logic [31:0] exp_rd(logic [3:0] a);
    if (a < 4)       return m_cnt[a];
    else if (a < 8)  return 32'(m_ctrl[a-4]);
    else if (a == 8) return 32'(m_sts);
    else if (a == 9) return 32'(m_msk);
    return '0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        m_cnt[i] = '0; m_rl[i] = '0; m_ctrl[i] = '0;
      end
      m_sts = '0; m_msk = '0; m_s1 = '0; m_s2 = '0; m_s3 = '0;
      m_pre = 0; m_pulse = 0;
    end else begin
      logic t16, t256, fire;
      logic [3:0] edg, set;
      t16  = (m_pre % 16) == 15;
      t256 = (m_pre == 255);
      m_pre = (m_pre + 1) % 256;
      edg = m_s2 & ~m_s3;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_in;
      set = '0; fire = 1'b0;
      for (int i = 0; i < 4; i++) begin
        logic [4:0] c;
        logic tk;
        c = m_ctrl[i];
        tk = c[0] && ((c[2:1] == 2'd0) || (c[2:1] == 2'd1 && (c[3] ? t256 : t16))
                      || (c[2:1] == 2'd2 && edg[i]));
        if (wr_en && addr == 4'(i)) begin
          m_cnt[i] = wr_data; m_rl[i] = wr_data;
        end else if (tk) begin
          if (m_cnt[i] == 0) begin
            if (!c[4]) m_cnt[i] = m_rl[i];
          end else begin
            m_cnt[i] = m_cnt[i] - 1;
            if (m_cnt[i] == 0) begin
              if (c[4]) fire = 1'b1;
              else      set[i] = 1'b1;
            end
          end
        end
      end
      if (wr_en && addr == 4'd8) m_sts = m_sts & ~wr_data[3:0];
      m_sts = m_sts | set;
      if (m_pulse > 0) m_pulse = m_pulse - 1;
      else if (fire)   m_pulse = 16;
      for (int i = 0; i < 4; i++)
        if (wr_en && addr == 4'(4 + i)) m_ctrl[i] = (i == 3) ? wr_data[4:0] : {1'b0, wr_data[3:0]};
      if (wr_en && addr == 4'd9) m_msk = wr_data[3:0];
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (started && rst_n) begin
      chk("R2 rd_data", rd_data, exp_rd(addr));
      chk("R8 irq_o", 32'(irq_o), 32'(|(m_sts & m_msk)));
      chk("R9 wdog_rst_o", 32'(wdog_rst_o), 32'(m_pulse > 0));
    end
  end

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] v);
    @(negedge clk); wr_en = 1'b0; addr = a;
    #1 v = rd_data;
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk); addr = 4'(rot); rot = (rot + 1) % 10;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] a, b;
    int hi;
    bit early;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    started = 1'b1;

    // R1: reset state
    for (int k = 0; k < 10; k++) begin
      rd(4'(k), a);
      chk("R1 reset register", a, 0);
    end
    chk("R1 irq_o", 32'(irq_o), 0);
    chk("R1 wdog_rst_o", 32'(wdog_rst_o), 0);

    // R3: reload write on disabled timer
    wr(0, 100);
    rd(0, a); chk("R3 reload loads count", a, 100);

    // R4: system clock counting
    wr(4, 1);
    rd(0, a); idle(10); rd(0, b);
    chk("R4 steps per cycle", a - b, 11);
    wr(4, 0);
    rd(0, a); idle(5); rd(0, b);
    chk("R4 disabled holds", b, a);
    wr(4, 7);
    rd(0, a); idle(5); rd(0, b);
    chk("R4 source none holds", b, a);
    rd(4, a); chk("R2 ctrl readback", a, 7);

    // R7: periodic interrupt
    wr(4, 0); wr(0, 5); wr(9, 1); wr(4, 1);
    idle(10);
    rd(8, a); chk("R7 status set at zero", a & 1, 1);
    chk("R8 irq with mask", 32'(irq_o), 1);

    // R8: clear and mask
    wr(4, 0); wr(8, 1);
    rd(8, a); chk("R8 W1C clears", a, 0);
    chk("R8 irq low after clear", 32'(irq_o), 0);
    wr(9, 0); wr(0, 2); wr(4, 1); idle(6);
    rd(8, a); chk("R8 status without mask", a & 1, 1);
    chk("R8 masked irq stays low", 32'(irq_o), 0);

    // R8: clear colliding with set, judged by the model every cycle
    wr(9, 1); wr(0, 3);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk); wr_en = 1'b1; addr = 4'd8; wr_data = 32'd1;
    end
    @(negedge clk); wr_en = 1'b0;
    idle(4);

    // R7: reload of zero never interrupts
    wr(4, 0); wr(8, 1); wr(0, 0); wr(4, 1);
    idle(20);
    rd(8, a); chk("R7 zero reload no status", a & 1, 0);
    wr(4, 0);

    // R5: prescaled sources
    wr(1, 1000); wr(5, 3);
    rd(1, a); idle(255); rd(1, b);
    chk("R5 ratio 16 over 256 cycles", a - b, 16);
    wr(5, 11);
    rd(1, a); idle(511); rd(1, b);
    chk("R5 ratio 256 over 512 cycles", a - b, 2);
    wr(5, 0);

    // R6: external pin edges
    wr(2, 2); wr(6, 5);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); ext_in[2] = 1'b1; idle(4);
      @(negedge clk); ext_in[2] = 1'b0; idle(4);
    end
    rd(2, a); chk("R6 two edges reach zero", a, 0);
    rd(8, a); chk("R6 status from pin", (a >> 2) & 1, 1);
    @(negedge clk); ext_in[2] = 1'b1; idle(6);
    rd(2, a); chk("R7 reload after zero", a, 2);
    @(negedge clk); ext_in[2] = 1'b0; idle(4);
    wr(6, 0);

    // R9: watchdog
    wr(8, 15); wr(3, 10); wr(7, 32'h11);
    early = 1'b0;
    for (int k = 0; k < 4; k++) begin
      for (int j = 0; j < 6; j++) begin
        @(negedge clk); if (wdog_rst_o) early = 1'b1;
      end
      wr(3, 10);
    end
    chk("R9 no reset while serviced", 32'(early), 0);
    hi = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk); if (wdog_rst_o) hi++;
    end
    chk("R9 pulse length", 32'(hi), 16);
    rd(3, a); chk("R9 holds at zero", a, 0);
    rd(8, a); chk("R9 no status in watchdog", (a >> 3) & 1, 0);
    wr(3, 5);
    rd(3, a); chk("R9 reload restarts", a, 4);
    wr(7, 0);
    idle(4);

    started = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule